// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory. Two comparator flags arrive already synchronized to the clock. One says the supply is above the write-protect level. The other says the supply is above the roughly 3 V level where the memory must run from its backup cell. From these two flags the block drives four registered controls:

- a write-block signal;
- a tristate request for the memory data outputs;
- a battery-select signal for the power switch;
- a threshold-pair select for the analog comparators.

The block also holds a one-time freshness seal. From factory reset the backup cell stays disconnected. It is armed the first time the supply is seen above the protect level, and it is never sealed again.

When the supply recovers, writes stay blocked for a recovery interval. This interval is measured as a count of pulses on a timebase tick input. The default of 125 ticks gives 125 ms with a 1 ms tick. If the supply dips during recovery, the count restarts from zero. The block reacts one clock after a flag change, so protection takes hold far inside a 1.5 µs budget for any practical clock.

The threshold-pair select chooses between two pairs:

- a narrow-tolerance pair: full function near 4.75 V, protection by 4.5 V;
- a wide-tolerance pair: full function near 4.5 V, protection by 4.25 V.

The select is taken from the `tol_wide` input only while writes are blocked. It therefore never moves the comparator levels under a live memory.

Top module: `pwr_guard`

## Requirements
- R1: In the cycle after synchronous reset is released, `wr_block`=1, `out_hiz`=1, `bat_sel`=0, `seal_intact`=1 and `thr_sel`=0.
- R2: While `seal_intact`=1, `bat_sel` stays 0 whatever `sup_sw_ok` does.
- R3: The first clock edge that samples `sup_prot_ok`=1 clears `seal_intact` in the next cycle. It stays 0 until reset.
- R4: A clock edge that samples `sup_prot_ok`=0 makes `wr_block`=1 and `out_hiz`=1 in the next cycle.
- R5: With the seal broken and `sup_prot_ok`=0, an edge that samples `sup_sw_ok`=0 gives `bat_sel`=1 in the next cycle. An edge that samples `sup_sw_ok`=1 gives `bat_sel`=0.
- R6: After `sup_prot_ok` returns to 1, writes stay blocked until exactly RECOV_TICKS edges have sampled `tick`=1. A tick sampled on the edge that starts recovery does not count. `wr_block` and `out_hiz` drop together, in the cycle after the edge that samples the last tick.
- R7: An edge that samples `sup_prot_ok`=0 during recovery discards all ticks counted so far. The next recovery needs the full RECOV_TICKS ticks again.
- R8: `bat_sel`=1 only while `wr_block`=1, and `out_hiz` always equals `wr_block`.
- R9: `thr_sel` loads `tol_wide` on every edge at which writes are blocked (`wr_block`=1) and holds its value while `wr_block`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (factory state, seal intact) |
| tick | input | 1 | One-cycle timebase pulse for the recovery interval |
| sup_prot_ok | input | 1 | Supply above write-protect level (synchronized) |
| sup_sw_ok | input | 1 | Supply above battery-switch level, about 3 V (synchronized) |
| tol_wide | input | 1 | Requested threshold pair: 1 = wide tolerance |
| wr_block | output | 1 | Memory write inhibit |
| out_hiz | output | 1 | Request to tristate memory outputs and ignore memory inputs |
| bat_sel | output | 1 | Connect backup cell to the memory array |
| seal_intact | output | 1 | Freshness seal still unbroken |
| thr_sel | output | 1 | Threshold pair applied to the comparators |

## Verification
The supply flags are swept through several patterns:

- a dip below 3 V while still sealed, which separates a seal that gates the battery path from one that does not;
- a clean first power-up, then a shallow dip that stays above 3 V and a deep dip to battery, which separates the protect-only path from the battery path;
- a dip partway through recovery, which shows whether the tick count is restarted or only paused;
- a toggle of the tolerance request during normal operation and again while protected, which tells a held select from a transparent one.

A behavioural reference model updated on every clock compares all outputs each cycle. The number of ticks consumed before writes are released is also counted directly.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [2:0] {
    PG_SEALED = 3'd0,
    PG_NORMAL = 3'd1,
    PG_PROT   = 3'd2,
    PG_BATT   = 3'd3,
    PG_RECOV  = 3'd4
  } pg_state_t;
endpackage

// File: rtl/pwr_guard_seal.sv
module pwr_guard_seal (
  input  logic clk,
  input  logic rst,
  input  logic supply_seen,
  output logic broken
);
  // one-time latch: cleared only by factory reset
  always_ff @(posedge clk) begin
    if (rst)              broken <= 1'b0;
    else if (supply_seen) broken <= 1'b1;
  end
endmodule

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer #(
  parameter int RECOV_TICKS = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = (RECOV_TICKS < 2) ? 1 : $clog2(RECOV_TICKS);
  localparam logic [CW-1:0] LAST = CW'(RECOV_TICKS - 1);

  logic [CW-1:0] cnt;

  assign expire = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      prot_ok,
  input  logic      sw_ok,
  input  logic      seal_broken,
  input  logic      recov_done,
  output pg_state_t state_q,
  output pg_state_t state_d
);
  always_comb begin
    state_d = state_q;
    if (!prot_ok) begin
      // supply below protect level: block at once, pick source by 3 V flag
      if (!seal_broken)  state_d = PG_SEALED;
      else if (!sw_ok)   state_d = PG_BATT;
      else               state_d = PG_PROT;
    end else begin
      unique case (state_q)
        PG_SEALED: state_d = PG_RECOV;
        PG_NORMAL: state_d = PG_NORMAL;
        PG_PROT:   state_d = PG_RECOV;
        PG_BATT:   state_d = PG_RECOV;
        PG_RECOV:  state_d = recov_done ? PG_NORMAL : PG_RECOV;
        default:   state_d = PG_PROT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PG_SEALED;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int RECOV_TICKS = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sup_prot_ok,
  input  logic sup_sw_ok,
  input  logic tol_wide,
  output logic wr_block,
  output logic out_hiz,
  output logic bat_sel,
  output logic seal_intact,
  output logic thr_sel
);
  pg_state_t st_q, st_d;
  logic      broken;
  logic      done;

  pwr_guard_seal u_seal (
    .clk         (clk),
    .rst         (rst),
    .supply_seen (sup_prot_ok),
    .broken      (broken)
  );

  pwr_guard_timer #(.RECOV_TICKS(RECOV_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (st_q == PG_RECOV),
    .tick   (tick),
    .expire (done)
  );

  pwr_guard_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .prot_ok     (sup_prot_ok),
    .sw_ok       (sup_sw_ok),
    .seal_broken (broken),
    .recov_done  (done),
    .state_q     (st_q),
    .state_d     (st_d)
  );

  // registered outputs decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_block <= 1'b1;
      out_hiz  <= 1'b1;
      bat_sel  <= 1'b0;
      thr_sel  <= 1'b0;
    end else begin
      wr_block <= (st_d != PG_NORMAL);
      out_hiz  <= (st_d != PG_NORMAL);
      bat_sel  <= (st_d == PG_BATT);
      if (st_q != PG_NORMAL) thr_sel <= tol_wide;
    end
  end

  assign seal_intact = !broken;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic sup_prot_ok,
  input logic sup_sw_ok,
  input logic wr_block,
  input logic out_hiz,
  input logic bat_sel,
  input logic seal_intact,
  input logic thr_sel
);
  a_r2_sealed_no_batt: assert property (@(posedge clk) disable iff (rst)
    seal_intact |-> !bat_sel);
  a_r3_seal_stays_broken: assert property (@(posedge clk) disable iff (rst)
    !seal_intact |=> !seal_intact);
  a_r4_protect_next: assert property (@(posedge clk) disable iff (rst)
    !sup_prot_ok |=> (wr_block && out_hiz));
  a_r5_batt_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_sel) |-> $past(!sup_sw_ok));
  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_block) |-> $past(tick && sup_prot_ok));
  a_r8_batt_blocked: assert property (@(posedge clk) disable iff (rst)
    bat_sel |-> (wr_block && out_hiz));
  a_r9_thr_held: assert property (@(posedge clk) disable iff (rst)
    !wr_block |=> $stable(thr_sel));
endmodule

bind pwr_guard pwr_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .sup_prot_ok (sup_prot_ok),
  .sup_sw_ok   (sup_sw_ok),
  .wr_block    (wr_block),
  .out_hiz     (out_hiz),
  .bat_sel     (bat_sel),
  .seal_intact (seal_intact),
  .thr_sel     (thr_sel)
);

// File: tb/pwr_guard_tb.sv
module pwr_guard_tb;
  localparam int N = 4;

  logic clk = 0, rst = 1, tick = 0, prot = 0, sw = 0, tolw = 0;
  logic wr_block, out_hiz, bat_sel, seal_intact, thr_sel;
  int checks = 0, errors = 0, cyc = 0, phase = 0, tk_total = 0;
  bit ten = 0;

  // reference model: 0 sealed,1 normal,2 prot,3 batt,4 recov
  int m_st = 0, m_cnt = 0;
  bit m_broken = 0, m_thr = 0;

  always #5 clk = ~clk;

  pwr_guard #(.RECOV_TICKS(N)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .sup_prot_ok(prot), .sup_sw_ok(sw),
    .tol_wide(tolw), .wr_block(wr_block), .out_hiz(out_hiz), .bat_sel(bat_sel),
    .seal_intact(seal_intact), .thr_sel(thr_sel));

  always @(posedge clk) begin
    int nx;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_broken = 0; m_thr = 0;
    end else begin
      if (m_st != 1) m_thr = tolw;
      nx = m_st;
      if (!prot) begin
        nx = !m_broken ? 0 : (!sw ? 3 : 2);
        m_cnt = 0;
      end else if (m_st == 4) begin
        if (tick) m_cnt++;
        if (m_cnt == N) begin nx = 1; m_cnt = 0; end
      end else if (m_st != 1) begin
        nx = 4; m_cnt = 0;
      end
      if (prot) m_broken = 1;
      m_st = nx;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R6 wr_block vs model", wr_block, m_st != 1);
      chk("R8 out_hiz vs model", out_hiz, m_st != 1);
      chk("R5 bat_sel vs model", bat_sel, m_st == 3);
      chk("R3 seal_intact vs model", seal_intact, !m_broken);
      chk("R9 thr_sel vs model", thr_sel, m_thr);
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic p, input logic s);
    @(posedge clk); #2;
    prot = p; sw = s;
    tick = ten && (phase == 2);
    phase = (phase + 1) % 3;
    if (tick) tk_total++;
  endtask

  task automatic run(input logic p, input logic s, input int n);
    for (int i = 0; i < n; i++) step(p, s);
  endtask

  task automatic measure_recovery(output int used);
    int start, prev;
    step(1, 1);
    ten = 1; start = tk_total; used = -1;
    for (int i = 0; i < 200; i++) begin
      prev = tk_total;
      step(1, 1);
      @(negedge clk);
      if (!wr_block) begin used = prev - start; break; end
    end
    ten = 0; tick = 0;
  endtask

  initial begin
    int used;
    run(0, 0, 3);
    @(posedge clk); #2 rst = 0;
    @(negedge clk);
    chk("R1 wr_block", wr_block, 1); chk("R1 out_hiz", out_hiz, 1);
    chk("R1 bat_sel", bat_sel, 0); chk("R1 seal_intact", seal_intact, 1);
    chk("R1 thr_sel", thr_sel, 0);
    // sealed: supply below 3 V must not select battery
    ten = 1; run(0, 0, 6); @(negedge clk);
    chk("R2 sealed bat_sel", bat_sel, 0);
    run(0, 1, 2); run(0, 0, 2); @(negedge clk);
    chk("R2 sealed bat_sel after toggle", bat_sel, 0);
    ten = 0; tick = 0;
    // first power-up
    measure_recovery(used);
    chk("R3 seal broken", seal_intact, 0);
    chk("R6 ticks to release", used == N, 1);
    // shallow dip
    step(0, 1); @(negedge clk); @(negedge clk);
    chk("R4 blocked next cycle", wr_block, 1); chk("R4 hiz next cycle", out_hiz, 1);
    chk("R5 no battery above 3V", bat_sel, 0);
    // deep dip
    step(0, 0); @(negedge clk); @(negedge clk);
    chk("R5 battery selected", bat_sel, 1); chk("R8 battery implies blocked", wr_block, 1);
    step(0, 1); @(negedge clk); @(negedge clk);
    chk("R5 battery released", bat_sel, 0);
    chk("R3 seal stays broken", seal_intact, 0);
    // partial recovery then dip: count restarts
    step(1, 1); ten = 1; run(1, 1, 8); ten = 0; tick = 0;
    @(negedge clk); chk("R7 still blocked mid-recovery", wr_block, 1);
    step(0, 1); run(0, 1, 2);
    measure_recovery(used);
    chk("R7 full tick count after restart", used == N, 1);
    // threshold select held while writable
    tolw = 1; run(1, 1, 4); @(negedge clk);
    chk("R9 thr held in normal", thr_sel, 0);
    step(0, 1); run(0, 1, 2); @(negedge clk);
    chk("R9 thr loaded when blocked", thr_sel, 1);
    tolw = 0; measure_recovery(used);
    chk("R9 thr follows while recovering", thr_sel, 0);
    tolw = 1; run(1, 1, 3); @(negedge clk);
    chk("R9 thr held again", thr_sel, 0);
    run(1, 1, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule